// File: doc/BRIEF.md
# Serial Port Register Front End

This block sits between a byte-wide memory-mapped bus and an asynchronous serial engine. It holds the engine's configuration (a 16-bit baud divisor written as two bytes, a line control byte, and one command byte each for the receive and transmit directions) and drives those values to the engine as plain outputs. Events that the engine reports are latched as sticky bits in two status registers, one for the line and one for the modem handshake. These events are received bytes, receive errors, break detection, handshake changes and transmitter progress. Software reads and tests these bits and raises an interrupt request from them.

Each status register can be reached at two addresses. A write at the first address knocks down every bit that is 1 in the written byte. A write at the second address forces those bits up, which lets software test the interrupt path. Received and transmitted bytes pass through one address. A read of it returns the receive holding byte and drops data-ready. A write to it fills the transmit holding byte that the engine later takes.

Top module: `serial_regfile`

## Requirements
- R1: After reset the line status reads 0x06 (both transmitter-empty bits set, all else clear), handshake status reads 0x00, the divisor, control and both command registers read 0x00, `irq` is 0 and `tx_pending` is 0.
- R2: Writes at 0x10 (divisor upper byte), 0x14 (divisor lower byte), 0x18 (control), 0x1C (receive command) and 0x20 (transmit command) read back unchanged at the same address. They also appear on `baud_div` = {upper, lower}, `line_ctrl`, `rx_cmd_o` and `tx_cmd_o`.
- R3: Line status is read at 0x00 and 0x04, and handshake status at 0x08 and 0x0C. A write to 0x00 or 0x08 clears exactly the bits written as 1. A write to 0x04 or 0x0C sets exactly those bits. Line status bit 0 and handshake bits 5..0 always read 0.
- R4: Engine pulses set line status bits: `rx_valid` sets data-ready 0x80 and captures `rx_byte`, framing 0x40, overrun 0x20, parity 0x10, break 0x08. `dsr_event` sets handshake bit 0x80 and `cts_event` sets 0x40.
- R5: An engine event in the same cycle as a clear write to the same bit leaves the bit set.
- R6: A read of 0x24 returns the latest received byte and clears data-ready, unless a new byte arrives in that same cycle.
- R7: A byte arriving while data-ready is already set also sets overrun (0x20) and replaces the held byte.
- R8: A write to 0x24 loads `tx_byte`, clears holding-empty (0x04) and raises `tx_pending`. A `tx_take` pulse sets holding-empty and clears shift-empty (0x02). A `tx_shift_done` pulse sets shift-empty.
- R9: Receive command byte: bit 7 enable, bits 6..5 transfer mode (01 interrupt, 10 and 11 DMA), bit 4 error interrupt enable. When enabled in interrupt mode, data-ready raises `irq`. In a DMA mode it does not.
- R10: With receive enable and the error interrupt enable both set, any of bits 0x78 in line status raises `irq`.
- R11: Transmit command byte: bit 7 enable, bits 6..5 mode, bit 4 empty interrupt. `irq` is raised when the transmitter is enabled and either the mode is 01 and holding-empty is set, or bit 4 is set and shift-empty is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address within the register window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access (side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| rx_valid | input | 1 | Engine delivered a received byte |
| rx_byte | input | 8 | Received byte, valid with `rx_valid` |
| rx_frame_err | input | 1 | Framing error pulse |
| rx_overrun | input | 1 | Engine-detected overrun pulse |
| rx_parity_err | input | 1 | Parity error pulse |
| rx_break | input | 1 | Break detected pulse |
| dsr_event | input | 1 | Data-set-ready change pulse |
| cts_event | input | 1 | Clear-to-send change pulse |
| tx_take | input | 1 | Engine moved the holding byte into its shifter |
| tx_shift_done | input | 1 | Engine finished shifting the last byte |
| tx_byte | output | 8 | Transmit holding byte |
| tx_pending | output | 1 | Holding byte waiting for the engine |
| baud_div | output | 16 | Baud divisor |
| line_ctrl | output | 8 | Line control byte |
| rx_cmd_o | output | 8 | Receive command byte |
| tx_cmd_o | output | 8 | Transmit command byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the engine pulses `tx_take` only while a byte is pending. They also assume that a bus access lasts one cycle, with at most one of the strobes tied to a single address. The stimulus drives every engine pulse and bus strobe for exactly one cycle, at the falling edge. It issues `tx_take` only after a write to 0x24. Apart from the one test that deliberately combines a clear write with an engine event on the same bit, it keeps engine events out of the cycles in which it accesses the bus.

// File: rtl/serial_regfile_pkg.sv
package serial_regfile_pkg;

    localparam int ADDR_W = 6;
    localparam int BYTE_W = 8;
    localparam int DIV_W  = 2 * BYTE_W;

    // Register window (byte offsets)
    localparam logic [ADDR_W-1:0] OFS_LINE_CLR  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_LINE_SET  = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_HAND_CLR  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_HAND_SET  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_DIV_UPPER = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_DIV_LOWER = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_CTRL      = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_RX_CMD    = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_TX_CMD    = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_DATA      = 6'h24;

    // Line status bit positions
    localparam int LN_READY   = 7;
    localparam int LN_FRAME   = 6;
    localparam int LN_OVERRUN = 5;
    localparam int LN_PARITY  = 4;
    localparam int LN_BREAK   = 3;
    localparam int LN_HOLD_MT = 2;
    localparam int LN_SHIFT_MT = 1;

    // Handshake status bit positions
    localparam int HS_DSR = 7;
    localparam int HS_CTS = 6;

    localparam logic [BYTE_W-1:0] LINE_MASK  = 8'hFE;
    localparam logic [BYTE_W-1:0] LINE_RESET = 8'h06;
    localparam logic [BYTE_W-1:0] HAND_MASK  = 8'hC0;

    typedef enum logic [1:0] {
        XFER_OFF   = 2'b00,
        XFER_IRQ   = 2'b01,
        XFER_DMA_A = 2'b10,
        XFER_DMA_B = 2'b11
    } xfer_mode_e;

    typedef struct packed {
        logic       en;
        xfer_mode_e mode;
        logic       err_ie;
        logic       pause_en;
        logic [2:0] spare;
    } rx_cmd_t;

    typedef struct packed {
        logic       en;
        xfer_mode_e mode;
        logic       empty_ie;
        logic       err_ie;
        logic       stop_pause;
        logic       brk_gen;
        logic       spare;
    } tx_cmd_t;

    typedef struct packed {
        logic line_clr;
        logic line_set;
        logic hand_clr;
        logic hand_set;
        logic div_upper;
        logic div_lower;
        logic ctrl;
        logic rx_cmd;
        logic tx_cmd;
        logic data_wr;
        logic data_rd;
    } strobe_t;

    function automatic logic [BYTE_W-1:0] bit_at(input int pos, input logic v);
        logic [BYTE_W-1:0] r;
        r = '0;
        r[pos] = v;
        return r;
    endfunction

endpackage

// File: rtl/sr_addr_decode.sv
module sr_addr_decode
    import serial_regfile_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output strobe_t           stb
);
    always_comb begin
        stb = '0;
        case (addr)
            OFS_LINE_CLR:  stb.line_clr  = wr;
            OFS_LINE_SET:  stb.line_set  = wr;
            OFS_HAND_CLR:  stb.hand_clr  = wr;
            OFS_HAND_SET:  stb.hand_set  = wr;
            OFS_DIV_UPPER: stb.div_upper = wr;
            OFS_DIV_LOWER: stb.div_lower = wr;
            OFS_CTRL:      stb.ctrl      = wr;
            OFS_RX_CMD:    stb.rx_cmd    = wr;
            OFS_TX_CMD:    stb.tx_cmd    = wr;
            OFS_DATA: begin
                stb.data_wr = wr;
                stb.data_rd = rd;
            end
            default: stb = '0;
        endcase
    end
endmodule

// File: rtl/sr_status_reg.sv
module sr_status_reg #(
    parameter int               W       = 8,
    parameter logic [W-1:0]     MASK    = '1,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sw_clr,
    input  logic         sw_set,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    input  logic [W-1:0] hw_clr,
    output logic [W-1:0] q
);
    logic [W-1:0] clr_bits, set_bits, nxt;

    always_comb begin
        clr_bits = (sw_clr ? wdata : '0) | hw_clr;
        set_bits = (sw_set ? wdata : '0);
        // engine events are ORed last so they beat any clear
        nxt = (((q & ~clr_bits) | set_bits) | hw_set) & MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL & MASK;
        else     q <= nxt;
    end
endmodule

// File: rtl/sr_irq_logic.sv
module sr_irq_logic
    import serial_regfile_pkg::*;
(
    input  logic [7:1]  line_st,
    input  logic        rx_en,
    input  xfer_mode_e  rx_mode,
    input  logic        rx_err_ie,
    input  logic        tx_en,
    input  xfer_mode_e  tx_mode,
    input  logic        tx_empty_ie,
    output logic        irq
);
    logic rx_data_req, rx_err_req, tx_hold_req, tx_shift_req;

    always_comb begin
        rx_data_req  = rx_en && (rx_mode == XFER_IRQ) && line_st[LN_READY];
        rx_err_req   = rx_en && rx_err_ie && (|line_st[LN_FRAME:LN_BREAK]);
        tx_hold_req  = tx_en && (tx_mode == XFER_IRQ) && line_st[LN_HOLD_MT];
        tx_shift_req = tx_en && tx_empty_ie && line_st[LN_SHIFT_MT];
        irq = rx_data_req | rx_err_req | tx_hold_req | tx_shift_req;
    end
endmodule

// File: rtl/serial_regfile.sv
module serial_regfile
    import serial_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_frame_err,
    input  logic              rx_overrun,
    input  logic              rx_parity_err,
    input  logic              rx_break,
    input  logic              dsr_event,
    input  logic              cts_event,
    input  logic              tx_take,
    input  logic              tx_shift_done,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_pending,
    output logic [DIV_W-1:0]  baud_div,
    output logic [BYTE_W-1:0] line_ctrl,
    output logic [BYTE_W-1:0] rx_cmd_o,
    output logic [BYTE_W-1:0] tx_cmd_o,
    output logic              irq
);
    strobe_t           stb;
    logic [BYTE_W-1:0] line_q, hand_q;
    logic [BYTE_W-1:0] div_upper_q, div_lower_q, ctrl_q;
    logic [BYTE_W-1:0] rx_hold_q, tx_hold_q;
    rx_cmd_t           rxc_q;
    tx_cmd_t           txc_q;
    logic [BYTE_W-1:0] line_hw_set, line_hw_clr, hand_hw_set;

    sr_addr_decode u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .stb  (stb)
    );

    always_comb begin
        line_hw_set = bit_at(LN_READY,    rx_valid)
                    | bit_at(LN_FRAME,    rx_frame_err)
                    | bit_at(LN_OVERRUN,  rx_overrun | (rx_valid & line_q[LN_READY]))
                    | bit_at(LN_PARITY,   rx_parity_err)
                    | bit_at(LN_BREAK,    rx_break)
                    | bit_at(LN_HOLD_MT,  tx_take & ~stb.data_wr)
                    | bit_at(LN_SHIFT_MT, tx_shift_done & ~tx_take);
        line_hw_clr = bit_at(LN_READY,    stb.data_rd)
                    | bit_at(LN_HOLD_MT,  stb.data_wr)
                    | bit_at(LN_SHIFT_MT, tx_take);
        hand_hw_set = bit_at(HS_DSR, dsr_event) | bit_at(HS_CTS, cts_event);
    end

    sr_status_reg #(.W(BYTE_W), .MASK(LINE_MASK), .RST_VAL(LINE_RESET)) u_line (
        .clk    (clk),
        .rst    (rst),
        .sw_clr (stb.line_clr),
        .sw_set (stb.line_set),
        .wdata  (bus_wdata),
        .hw_set (line_hw_set),
        .hw_clr (line_hw_clr),
        .q      (line_q)
    );

    sr_status_reg #(.W(BYTE_W), .MASK(HAND_MASK), .RST_VAL('0)) u_hand (
        .clk    (clk),
        .rst    (rst),
        .sw_clr (stb.hand_clr),
        .sw_set (stb.hand_set),
        .wdata  (bus_wdata),
        .hw_set (hand_hw_set),
        .hw_clr ('0),
        .q      (hand_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            div_upper_q <= '0;
            div_lower_q <= '0;
            ctrl_q      <= '0;
            rxc_q       <= '0;
            txc_q       <= '0;
            rx_hold_q   <= '0;
            tx_hold_q   <= '0;
        end else begin
            if (stb.div_upper) div_upper_q <= bus_wdata;
            if (stb.div_lower) div_lower_q <= bus_wdata;
            if (stb.ctrl)      ctrl_q      <= bus_wdata;
            if (stb.rx_cmd)    rxc_q       <= rx_cmd_t'(bus_wdata);
            if (stb.tx_cmd)    txc_q       <= tx_cmd_t'(bus_wdata);
            if (stb.data_wr)   tx_hold_q   <= bus_wdata;
            if (rx_valid)      rx_hold_q   <= rx_byte;
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_LINE_CLR, OFS_LINE_SET: bus_rdata = line_q;
            OFS_HAND_CLR, OFS_HAND_SET: bus_rdata = hand_q;
            OFS_DIV_UPPER:              bus_rdata = div_upper_q;
            OFS_DIV_LOWER:              bus_rdata = div_lower_q;
            OFS_CTRL:                   bus_rdata = ctrl_q;
            OFS_RX_CMD:                 bus_rdata = rxc_q;
            OFS_TX_CMD:                 bus_rdata = txc_q;
            OFS_DATA:                   bus_rdata = rx_hold_q;
            default:                    bus_rdata = '0;
        endcase
    end

    sr_irq_logic u_irq (
        .line_st     (line_q[7:1]),
        .rx_en       (rxc_q.en),
        .rx_mode     (rxc_q.mode),
        .rx_err_ie   (rxc_q.err_ie),
        .tx_en       (txc_q.en),
        .tx_mode     (txc_q.mode),
        .tx_empty_ie (txc_q.empty_ie),
        .irq         (irq)
    );

    assign tx_byte    = tx_hold_q;
    assign tx_pending = ~line_q[LN_HOLD_MT];
    assign baud_div   = {div_upper_q, div_lower_q};
    assign line_ctrl  = ctrl_q;
    assign rx_cmd_o   = rxc_q;
    assign tx_cmd_o   = txc_q;
endmodule

// File: rtl/serial_regfile_chk.sv
module serial_regfile_chk
    import serial_regfile_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic              rx_valid,
    input logic              tx_take,
    input logic [BYTE_W-1:0] tx_byte,
    input logic              tx_pending,
    input logic [BYTE_W-1:0] line_ctrl,
    input logic [BYTE_W-1:0] rx_cmd_o,
    input logic [BYTE_W-1:0] tx_cmd_o,
    input logic              irq,
    input logic [BYTE_W-1:0] line_q
);
    logic data_wr_c, data_rd_c;
    assign data_wr_c = bus_wr && (bus_addr == OFS_DATA);
    assign data_rd_c = bus_rd && (bus_addr == OFS_DATA);

    assert_line_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (line_q == LINE_RESET));

    assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CTRL) |=> (line_ctrl == $past(bus_wdata)));

    assert_event_wins_R5: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> line_q[LN_READY]);

    assert_read_drops_ready_R6: assert property (@(posedge clk) disable iff (rst)
        (data_rd_c && !rx_valid) |=> !line_q[LN_READY]);

    assert_overrun_on_full_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && line_q[LN_READY]) |=> line_q[LN_OVERRUN]);

    assert_tx_load_R8: assert property (@(posedge clk) disable iff (rst)
        data_wr_c |=> (tx_pending && tx_byte == $past(bus_wdata)));

    assert_take_empties_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_take && !data_wr_c) |=> !tx_pending);

    assert_take_when_full_R8: assert property (@(posedge clk) disable iff (rst)
        tx_take |-> tx_pending);

    assert_quiet_when_disabled_R9: assert property (@(posedge clk) disable iff (rst)
        (!rx_cmd_o[7] && !tx_cmd_o[7]) |-> !irq);
endmodule

bind serial_regfile serial_regfile_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .rx_valid   (rx_valid),
    .tx_take    (tx_take),
    .tx_byte    (tx_byte),
    .tx_pending (tx_pending),
    .line_ctrl  (line_ctrl),
    .rx_cmd_o   (rx_cmd_o),
    .tx_cmd_o   (tx_cmd_o),
    .irq        (irq),
    .line_q     (line_q)
);

// File: tb/serial_regfile_test.sv
module serial_regfile_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_frame_err = 1'b0, rx_overrun = 1'b0, rx_parity_err = 1'b0, rx_break = 1'b0;
    logic       dsr_event = 1'b0, cts_event = 1'b0, tx_take = 1'b0, tx_shift_done = 1'b0;
    logic [7:0] tx_byte, line_ctrl, rx_cmd_o, tx_cmd_o;
    logic [15:0] baud_div;
    logic       tx_pending, irq;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    serial_regfile uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_frame_err(rx_frame_err), .rx_overrun(rx_overrun), .rx_parity_err(rx_parity_err),
        .rx_break(rx_break), .dsr_event(dsr_event), .cts_event(cts_event), .tx_take(tx_take),
        .tx_shift_done(tx_shift_done), .tx_byte(tx_byte), .tx_pending(tx_pending),
        .baud_div(baud_div), .line_ctrl(line_ctrl), .rx_cmd_o(rx_cmd_o), .tx_cmd_o(tx_cmd_o),
        .irq(irq)
    );

    // {is_write, addr[5:0], data[7:0], expected read[7:0]}
    localparam int NV = 20;
    localparam logic [22:0] VEC [NV] = '{
        {1'b1, 6'h10, 8'h12, 8'h00},
        {1'b1, 6'h14, 8'h34, 8'h00},
        {1'b0, 6'h10, 8'h00, 8'h12},
        {1'b0, 6'h14, 8'h00, 8'h34},
        {1'b1, 6'h18, 8'h5A, 8'h00},
        {1'b0, 6'h18, 8'h00, 8'h5A},
        {1'b1, 6'h04, 8'h78, 8'h00},
        {1'b0, 6'h00, 8'h00, 8'h7E},
        {1'b0, 6'h04, 8'h00, 8'h7E},
        {1'b1, 6'h00, 8'h50, 8'h00},
        {1'b0, 6'h00, 8'h00, 8'h2E},
        {1'b1, 6'h00, 8'hFF, 8'h00},
        {1'b0, 6'h00, 8'h00, 8'h00},
        {1'b1, 6'h04, 8'hFF, 8'h00},
        {1'b0, 6'h04, 8'h00, 8'hFE},
        {1'b1, 6'h0C, 8'hFF, 8'h00},
        {1'b0, 6'h08, 8'h00, 8'hC0},
        {1'b1, 6'h08, 8'h40, 8'h00},
        {1'b0, 6'h0C, 8'h00, 8'h80},
        {1'b1, 6'h08, 8'hFF, 8'h00}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, {8'h00, d}, {8'h00, exp});
    endtask

    task automatic rx_in(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk("R1 line", 6'h00, 8'h06);
        rd_chk("R1 hand", 6'h08, 8'h00);
        rd_chk("R1 div hi", 6'h10, 8'h00);
        rd_chk("R1 div lo", 6'h14, 8'h00);
        rd_chk("R1 ctrl", 6'h18, 8'h00);
        rd_chk("R1 rxcmd", 6'h1C, 8'h00);
        rd_chk("R1 txcmd", 6'h20, 8'h00);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 tx_pending", {15'd0, tx_pending}, 16'd0);

        // R2 / R3 table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][22]) wr(VEC[i][21:16], VEC[i][15:8]);
            else rd_chk("R2/R3 vector", VEC[i][21:16], VEC[i][7:0]);
        end
        rd_chk("R3 hand cleared", 6'h08, 8'h00);
        chk("R2 baud_div", baud_div, 16'h1234);
        chk("R2 line_ctrl", {8'h00, line_ctrl}, 16'h005A);
        wr(6'h00, 8'hFF); wr(6'h04, 8'h06);
        rd_chk("R3 restored", 6'h00, 8'h06);

        // R4 / R6 receive
        rx_in(8'hA5);
        rd_chk("R4 ready bit", 6'h00, 8'h86);
        rd_chk("R6 data", 6'h24, 8'hA5);
        rd_chk("R6 ready cleared", 6'h00, 8'h06);

        // R7 overrun
        rx_in(8'h11);
        rx_in(8'h22);
        rd_chk("R7 overrun bit", 6'h00, 8'hA6);
        rd_chk("R7 newest byte", 6'h24, 8'h22);
        wr(6'h00, 8'h20);
        rd_chk("R7 cleared", 6'h00, 8'h06);

        // R4 error and handshake events
        @(negedge clk);
        rx_frame_err = 1; rx_parity_err = 1; rx_break = 1; dsr_event = 1; cts_event = 1;
        @(negedge clk);
        rx_frame_err = 0; rx_parity_err = 0; rx_break = 0; dsr_event = 0; cts_event = 0;
        rd_chk("R4 errors", 6'h00, 8'h5E);
        rd_chk("R4 handshake", 6'h08, 8'hC0);
        wr(6'h00, 8'h78); wr(6'h08, 8'hFF);
        rd_chk("R3 clear 0x78", 6'h00, 8'h06);

        // R5 event beats clear in same cycle
        @(negedge clk);
        bus_addr = 6'h00; bus_wdata = 8'h40; bus_wr = 1; rx_frame_err = 1;
        @(negedge clk);
        bus_wr = 0; rx_frame_err = 0;
        rd_chk("R5 frame kept", 6'h00, 8'h46);
        wr(6'h00, 8'h40);

        // R8 transmit path
        wr(6'h24, 8'hC3);
        chk("R8 tx_pending", {15'd0, tx_pending}, 16'd1);
        chk("R8 tx_byte", {8'h00, tx_byte}, 16'h00C3);
        rd_chk("R8 hold busy", 6'h00, 8'h02);
        @(negedge clk); tx_take = 1; @(negedge clk); tx_take = 0;
        chk("R8 taken", {15'd0, tx_pending}, 16'd0);
        rd_chk("R8 shifting", 6'h00, 8'h04);
        @(negedge clk); tx_shift_done = 1; @(negedge clk); tx_shift_done = 0;
        rd_chk("R8 idle", 6'h00, 8'h06);

        // R9 receive interrupt
        wr(6'h1C, 8'hA0);
        rd_chk("R2 rxcmd", 6'h1C, 8'hA0);
        chk("R9 no data", {15'd0, irq}, 16'd0);
        rx_in(8'h01);
        chk("R9 data irq", {15'd0, irq}, 16'd1);
        rd_chk("R9 drain", 6'h24, 8'h01);
        chk("R9 drained", {15'd0, irq}, 16'd0);
        wr(6'h1C, 8'hC0);
        rx_in(8'h02);
        chk("R9 dma mode quiet", {15'd0, irq}, 16'd0);
        rd_chk("R9 dma drain", 6'h24, 8'h02);

        // R10 error interrupt
        wr(6'h1C, 8'h10);
        @(negedge clk); rx_parity_err = 1; @(negedge clk); rx_parity_err = 0;
        chk("R10 rx disabled", {15'd0, irq}, 16'd0);
        wr(6'h1C, 8'h90);
        chk("R10 error irq", {15'd0, irq}, 16'd1);
        wr(6'h00, 8'h10);
        chk("R10 cleared", {15'd0, irq}, 16'd0);
        wr(6'h1C, 8'h00);

        // R11 transmit interrupt
        wr(6'h20, 8'hA0);
        rd_chk("R2 txcmd", 6'h20, 8'hA0);
        chk("R11 hold empty irq", {15'd0, irq}, 16'd1);
        wr(6'h20, 8'h90);
        chk("R11 shift empty irq", {15'd0, irq}, 16'd1);
        wr(6'h24, 8'h55);
        chk("R11 shift still empty", {15'd0, irq}, 16'd1);
        @(negedge clk); tx_take = 1; @(negedge clk); tx_take = 0;
        chk("R11 shifting quiet", {15'd0, irq}, 16'd0);
        wr(6'h20, 8'h80);
        @(negedge clk); tx_shift_done = 1; @(negedge clk); tx_shift_done = 0;
        chk("R11 no enable bits", {15'd0, irq}, 16'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule